// File: doc/BRIEF.md
# Indirect Jump Landing Lock

This block sits beside the commit stage of an out-of-order core and enforces a reduced form of control-flow locking. Each committed instruction comes with two flags. One says the instruction is an indirect jump. The other says it carries a landing marker, a dedicated opcode or prefix placed at every legal indirect-jump target. Committing an indirect jump arms a single lock bit. The lock carries no key or value. The next instruction to commit must carry a landing marker, which releases the lock. If any other instruction commits in that position, the block reports a violation.

Up to four instructions retire per cycle. They are walked in program order, lowest slot first, so a jump and its landing can retire together. The commit stream is valid-only: retirement cannot be stalled, so the block has no ready signal and accepts every valid slot in the cycle it is presented. A violation produces a one-cycle fault pulse. The pulse carries the PC and slot of the offending instruction. The lock then stays held until the pipeline flushes, which the exception entry that follows a fault always causes. The check can be switched off; while it is off the lock is held open.

Top module: `jump_lock_checker`

## Requirements
- R1: After reset, `lock_active` is 0 and `fault_valid` is 0.
- R2: A committed instruction with `commit_ijmp` set, and no later valid slot in the same cycle, makes `lock_active` read 1 in the following cycle.
- R3: While locked, the next valid committed instruction with `commit_mark` set releases the lock. Any number of idle cycles or invalid slots may come between the jump and the marker.
- R4: While locked, a valid committed instruction without `commit_mark` is a violation. One cycle after that commit, `fault_valid` is 1, `fault_pc` is that instruction's PC and `fault_slot` is its slot index (0 to 3).
- R5: An instruction with `commit_mark` set that commits while unlocked changes nothing and raises no fault.
- R6: Slot i's valid, jump flag, marker flag and PC are bit i of `commit_valid`, `commit_ijmp` and `commit_mark`, and bits [i*32 +: 32] of `commit_pc`. Slots are evaluated in ascending order, so a lock set in slot i applies to the next valid slot above i in the same cycle. Only the first violation of a cycle is reported.
- R7: After a violation, `lock_active` stays 1 and no further fault is raised until a flush or until the check is disabled.
- R8: `pipe_flush` makes `lock_active` read 0 in the next cycle without a fault. Commits presented in the flush cycle are ignored.
- R9: While `chk_enable` is 0, commits are ignored, no fault is raised, and `lock_active` reads 0 from the next cycle.
- R10: An instruction with both flags set that commits while locked releases the lock and then re-arms it, without a fault.
- R11: `fault_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_enable | input | 1 | Check on; when 0 the lock is held open |
| pipe_flush | input | 1 | Pipeline flush or exception entry |
| commit_valid | input | 4 | Per-slot retirement valid |
| commit_ijmp | input | 4 | Per-slot indirect jump flag |
| commit_mark | input | 4 | Per-slot landing marker flag |
| commit_pc | input | 128 | Per-slot PC, 32 bits per slot |
| lock_active | output | 1 | Lock armed, or held after a fault |
| fault_valid | output | 1 | One-cycle violation pulse |
| fault_pc | output | 32 | PC of the violating instruction |
| fault_slot | output | 2 | Slot of the violating instruction |

## Verification
The bench starts from both the open and the armed state and applies every combination of valid, jump and marker bits across the four slots. This catches a chain that evaluates slots out of order or lets an invalid slot consume the lock. It also catches a design that reports the second violation of a cycle rather than the first, with the wrong PC or slot, or that faults when a marker arrives while unlocked. Directed cases cover the following:
- idle cycles between a jump and its marker, which a design that times the lock out would fail;
- a flush carrying commits, which a design that evaluates before clearing would turn into a fault;
- disable while armed;
- the period after a fault, where a non-sticky design would release the lock or pulse again.

// File: rtl/jl_pkg.sv
package jl_pkg;
  // Lock states: open, armed by an indirect jump, tripped after a violation.
  typedef enum logic [1:0] {
    LK_OPEN    = 2'd0,
    LK_ARMED   = 2'd1,
    LK_TRIPPED = 2'd2
  } lk_state_e;
endpackage

// File: rtl/jl_slot_step.sv
module jl_slot_step
  import jl_pkg::*;
(
  input  lk_state_e st_in,
  input  logic      slot_valid,
  input  logic      slot_ijmp,
  input  logic      slot_mark,
  output lk_state_e st_out,
  output logic      slot_viol
);
  // One retiring instruction applied to the lock state.
  always_comb begin
    st_out    = st_in;
    slot_viol = 1'b0;
    if (slot_valid) begin
      case (st_in)
        LK_OPEN: begin
          // A marker here is harmless; a jump arms the lock.
          if (slot_ijmp) st_out = LK_ARMED;
        end
        LK_ARMED: begin
          if (slot_mark) begin
            // Release first, then re-arm if this landing is itself a jump.
            st_out = slot_ijmp ? LK_ARMED : LK_OPEN;
          end else begin
            st_out    = LK_TRIPPED;
            slot_viol = 1'b1;
          end
        end
        default: st_out = LK_TRIPPED;
      endcase
    end
  end
endmodule

// File: rtl/jl_commit_chain.sv
module jl_commit_chain
  import jl_pkg::*;
#(
  parameter int COMMIT_W = 4,
  parameter int PC_W     = 32,
  parameter int SLOT_W   = 2
) (
  input  lk_state_e                  st_start,
  input  logic [COMMIT_W-1:0]        c_valid,
  input  logic [COMMIT_W-1:0]        c_ijmp,
  input  logic [COMMIT_W-1:0]        c_mark,
  input  logic [COMMIT_W*PC_W-1:0]   c_pc,
  output lk_state_e                  st_end,
  output logic                       any_viol,
  output logic [COMMIT_W-1:0]        viol_vec,
  output logic [PC_W-1:0]            viol_pc,
  output logic [SLOT_W-1:0]          viol_slot
);
  lk_state_e st_link [COMMIT_W+1];

  assign st_link[0] = st_start;

  // Program-order ripple: each slot sees the state left by the slots below it.
  for (genvar g = 0; g < COMMIT_W; g++) begin : g_slot
    jl_slot_step u_step (
      .st_in      (st_link[g]),
      .slot_valid (c_valid[g]),
      .slot_ijmp  (c_ijmp[g]),
      .slot_mark  (c_mark[g]),
      .st_out     (st_link[g+1]),
      .slot_viol  (viol_vec[g])
    );
  end

  assign st_end   = st_link[COMMIT_W];
  assign any_viol = |viol_vec;

  // Lowest violating slot wins.
  always_comb begin
    viol_pc   = '0;
    viol_slot = '0;
    for (int i = COMMIT_W - 1; i >= 0; i--) begin
      if (viol_vec[i]) begin
        viol_pc   = c_pc[i*PC_W +: PC_W];
        viol_slot = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/jump_lock_checker.sv
module jump_lock_checker
  import jl_pkg::*;
#(
  parameter int COMMIT_W = 4,
  parameter int PC_W     = 32,
  localparam int SLOT_W  = (COMMIT_W > 1) ? $clog2(COMMIT_W) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chk_enable,
  input  logic                      pipe_flush,
  input  logic [COMMIT_W-1:0]       commit_valid,
  input  logic [COMMIT_W-1:0]       commit_ijmp,
  input  logic [COMMIT_W-1:0]       commit_mark,
  input  logic [COMMIT_W*PC_W-1:0]  commit_pc,
  output logic                      lock_active,
  output logic                      fault_valid,
  output logic [PC_W-1:0]           fault_pc,
  output logic [SLOT_W-1:0]         fault_slot
);
  lk_state_e              st_q, st_d, st_chain;
  logic                   any_viol;
  logic [COMMIT_W-1:0]    viol_vec;
  logic [PC_W-1:0]        viol_pc;
  logic [SLOT_W-1:0]      viol_slot;
  logic                   accept;

  // Flush and disable both discard the cycle's commits.
  assign accept = chk_enable && !pipe_flush;

  jl_commit_chain #(
    .COMMIT_W (COMMIT_W),
    .PC_W     (PC_W),
    .SLOT_W   (SLOT_W)
  ) u_chain (
    .st_start  (st_q),
    .c_valid   (commit_valid),
    .c_ijmp    (commit_ijmp),
    .c_mark    (commit_mark),
    .c_pc      (commit_pc),
    .st_end    (st_chain),
    .any_viol  (any_viol),
    .viol_vec  (viol_vec),
    .viol_pc   (viol_pc),
    .viol_slot (viol_slot)
  );

  always_comb begin
    st_d = accept ? st_chain : LK_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= LK_OPEN;
      fault_valid <= 1'b0;
      fault_pc    <= '0;
      fault_slot  <= '0;
    end else begin
      st_q        <= st_d;
      fault_valid <= accept && any_viol;
      if (accept && any_viol) begin
        fault_pc   <= viol_pc;
        fault_slot <= viol_slot;
      end
    end
  end

  assign lock_active = (st_q != LK_OPEN);

  // R6: at most one slot can trip per cycle, since the state is then tripped
  single_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(viol_vec));

  // R11
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  // R7
  fault_holds_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> lock_active);

  // R7
  tripped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_TRIPPED && accept) |=> (st_q == LK_TRIPPED && !fault_valid));

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_flush |=> (!lock_active && !fault_valid));

  // R9
  disable_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_enable |=> (!lock_active && !fault_valid));
endmodule

// File: tb/tb_jump_lock_checker.sv
module tb_jump_lock_checker;
  localparam int CW = 4;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          fl = 1'b0;
  logic [CW-1:0] cv = '0, ci = '0, cm = '0;
  logic [CW*PW-1:0] cpc = '0;
  logic          lock_active, fault_valid;
  logic [PW-1:0] fault_pc;
  logic [1:0]    fault_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  jump_lock_checker #(.COMMIT_W(CW), .PC_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .chk_enable(en), .pipe_flush(fl),
    .commit_valid(cv), .commit_ijmp(ci), .commit_mark(cm), .commit_pc(cpc),
    .lock_active(lock_active), .fault_valid(fault_valid),
    .fault_pc(fault_pc), .fault_slot(fault_slot)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pc_of(input int tag, input int s);
    return PW'(32'h4000_0000 + tag * 16 + s * 4);
  endfunction

  // pattern: slot s uses bits [3s+2:3s] = {valid, ijmp, mark}
  task automatic drive(input int pat, input int tag);
    for (int s = 0; s < CW; s++) begin
      cv[s] = pat[3*s+2];
      ci[s] = pat[3*s+1];
      cm[s] = pat[3*s];
      cpc[s*PW +: PW] = pc_of(tag, s);
    end
  endtask

  task automatic idle();
    cv = '0; ci = '0; cm = '0; fl = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Reference: state 0 open, 1 armed, 2 tripped
  function automatic void model(input int start, input int pat,
                                output int st, output bit f, output int fs);
    st = start; f = 0; fs = 0;
    for (int s = 0; s < CW; s++) begin
      if (pat[3*s+2] && st != 2) begin
        if (st == 1 && !pat[3*s]) begin
          st = 2; f = 1; fs = s;
        end else begin
          if (st == 1) st = 0;
          if (pat[3*s+1]) st = 1;
        end
      end
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int st; bit f; int fs;
    tick(); tick();
    // R1
    check("R1", "lock after reset", lock_active, 0);
    check("R1", "fault after reset", fault_valid, 0);
    rst_n = 1'b1; en = 1'b1;
    tick();

    // R5: marker while open
    drive(12'b000_000_000_101, 1); tick();
    idle();
    check("R5", "lock", lock_active, 0);
    check("R5", "fault", fault_valid, 0);

    // R2 then R3 with idle gap
    drive(12'b000_000_000_110, 2); tick();
    idle();
    check("R2", "lock", lock_active, 1);
    tick(); tick(); tick();
    check("R3", "lock held over idle", lock_active, 1);
    drive(12'b000_000_101_000, 3); tick();
    idle();
    check("R3", "lock released", lock_active, 0);
    check("R3", "no fault", fault_valid, 0);

    // R4: armed, then non-marker in slot 2
    drive(12'b000_000_000_110, 4); tick();
    drive(12'b000_100_000_000, 5); tick();
    idle();
    check("R4", "fault_valid", fault_valid, 1);
    check("R4", "fault_pc", fault_pc, pc_of(5, 2));
    check("R4", "fault_slot", fault_slot, 2);
    // R7 and R11: sticky, no second pulse
    drive(12'b100_100_100_100, 6); tick();
    idle();
    check("R11", "no second pulse", fault_valid, 0);
    check("R7", "lock held", lock_active, 1);
    // R8: flush with commits present
    fl = 1'b1; drive(12'b100_100_100_110, 7); tick();
    idle();
    check("R8", "lock cleared", lock_active, 0);
    check("R8", "no fault", fault_valid, 0);

    // R10: dual-flag landing while armed
    drive(12'b000_000_000_110, 8); tick();
    drive(12'b000_000_000_111, 9); tick();
    idle();
    check("R10", "re-armed", lock_active, 1);
    check("R10", "no fault", fault_valid, 0);
    // R9: disable while armed; commits ignored
    en = 1'b0; drive(12'b100_100_110_100, 10); tick();
    check("R9", "lock forced open", lock_active, 0);
    check("R9", "no fault", fault_valid, 0);
    tick();
    check("R9", "still open", lock_active, 0);
    check("R9", "still no fault", fault_valid, 0);
    en = 1'b1; idle(); tick();

    // R6: exhaustive sweep from open and armed
    for (int start = 0; start < 2; start++) begin
      for (int pat = 0; pat < 4096; pat++) begin
        fl = 1'b1; tick(); idle();
        if (start == 1) begin
          drive(12'b000_000_000_110, 0); tick(); idle();
        end
        drive(pat, pat + 1); tick(); idle();
        model(start, pat, st, f, fs);
        check("R6", "sweep lock", lock_active, (st != 0) ? 1 : 0);
        check("R6", "sweep fault", fault_valid, f);
        if (f) begin
          check("R6", "sweep fault_pc", fault_pc, pc_of(pat + 1, fs));
          check("R6", "sweep fault_slot", fault_slot, fs);
          tick();
          check("R7", "sweep sticky", lock_active, 1);
          check("R11", "sweep single pulse", fault_valid, 0);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule